// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is a soft model of a one-time-programmable AND/OR/invert logic array. It has 16 input variables, 48 product terms and 8 output functions. Every product term is the AND of any chosen inputs. Each input can be used in true form, in complement form, or left out. Every output is the OR of any chosen product terms, passed through a per-output inverter that can be switched on or off.

All connections live in one configuration shift register. That register is loaded one bit per clock while the program strobe is high. The bit pushed off its far end appears on the serial output, so the old configuration can be read back while a new one is loaded. Outside programming, the outputs follow the inputs combinationally. A chip enable gates the outputs: when it is low, the output-enable vector is all zeros (high impedance) and the data outputs are held at 0.

After reset every connection is present: all AND links, all OR links, and no inversion. Each product term then sees an input and its complement together, so it evaluates to 0. As a result, every output reads 0 until the array is programmed.

Top module: `sop_array_top`

## Requirements
- R1: After reset the configuration is all ones in the AND and OR planes and all zeros in the polarity bits, so with chip enable high every output is 0 and every output enable is 1.
- R2: While `prog_en` is high, the configuration register shifts once per rising clock edge. `cfg_in` enters bit 0, and `cfg_out` always shows the top bit (the next bit to be displaced), so a full load of W bits presented MSB-first places the first bit in bit W-1.
- R3: While `prog_en` is low, the configuration does not change, whatever `cfg_in` does.
- R4: Configuration layout, from bit 0 upward: first the polarity bits, one per output (bit o for output o). Next the OR links, with the link from term t to output o at bit N_OUT + o*N_TERM + t. Last the AND links, starting at A = N_OUT + N_OUT*N_TERM: bit A + t*2*N_IN + 2*i + 1 uses input i in true form in term t, and bit A + t*2*N_IN + 2*i uses its complement.
- R5: A product term with only the true link of an input set is 0 whenever that input is 0. A term with only the complement link set is 0 whenever that input is 1.
- R6: An input with neither link set in a term has no effect on that term, and a term with no links set is constant 1.
- R7: An input with both links set forces its term to 0 for every input vector.
- R8: Each output is the OR of the terms whose OR link to it is set. Terms without a link contribute 0, and an output with no links gives 0 before polarity.
- R9: A polarity bit of 1 inverts its output's OR result; a polarity bit of 0 passes it unchanged.
- R10: With `chip_en` low, `dout_oe` is all zeros and `dout` is all zeros. With `chip_en` high, `dout_oe` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration register |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_en | input | 1 | Shift the configuration register by one bit per clock |
| cfg_in | input | 1 | Serial configuration data, MSB first |
| cfg_out | output | 1 | Top bit of the configuration register (next bit displaced) |
| chip_en | input | 1 | Output enable; low disables all outputs |
| din | input | N_IN | Input variables |
| dout | output | N_OUT | Output functions, 0 when disabled |
| dout_oe | output | N_OUT | Per-output drive enable, 0 means high impedance |

## Verification
The bench uses a reduced array of 4 inputs, 6 terms and 3 outputs. It sweeps all 16 input vectors after every configuration load, so each output function is checked over its complete truth table.

Two hand-built configurations mix true links, complement links, unused inputs, dead terms and multi-term sums, under both polarities. They tell the four link encodings apart and expose an inverter that is missing or applied twice.

Random configurations are then swept with chip enable both high and low. Each new load reads back the previous configuration bit by bit, which separates a wrong shift order from a wrong plane mapping. A stretch of toggling `cfg_in` with the program strobe low shows whether the configuration is held.

// File: rtl/sop_pkg.sv
// Package: shared helpers for the sum-of-products array.
// Assumes the configuration layout {AND plane, OR plane, polarity}
// with the polarity bits at the least significant end.
package sop_pkg;

    // Total configuration width for a given array geometry
    function automatic int cfg_width(input int n_in, input int n_term, input int n_out);
        return 2 * n_in * n_term + n_term * n_out + n_out;
    endfunction

    // Index of the true-form link of input i in term t, inside the AND plane
    function automatic int and_true_idx(input int t, input int i, input int n_in);
        return t * 2 * n_in + 2 * i + 1;
    endfunction

    // Index of the complement-form link of input i in term t, inside the AND plane
    function automatic int and_comp_idx(input int t, input int i, input int n_in);
        return t * 2 * n_in + 2 * i;
    endfunction

endpackage

// File: rtl/sop_cfg_chain.sv
// Module: serial configuration register.
// Shifts left by one bit per clock while shift_en is high: ser_in enters
// bit 0 and ser_out shows the top bit. Reset loads RESET_VAL.
// Assumes a synchronous active-low reset.
module sop_cfg_chain #(
    parameter int            WIDTH     = 8,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             ser_in,
    output logic             ser_out,
    output logic [WIDTH-1:0] chain_q
);

    // Load the reset pattern, or shift one bit in when enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= RESET_VAL;
        end else if (shift_en) begin
            chain_q <= {chain_q[WIDTH-2:0], ser_in};
        end
    end

    // The bit that the next shift will push out
    assign ser_out = chain_q[WIDTH-1];

endmodule

// File: rtl/sop_and_plane.sv
// Module: AND plane.
// Each product term ANDs the selected literals. Per input and term there
// are two links: true-form and complement-form. No link means don't care;
// both links force the term to 0. Purely combinational.
module sop_and_plane
    import sop_pkg::*;
#(
    parameter int N_IN   = 16,
    parameter int N_TERM = 48,
    localparam int LINK_W = 2 * N_IN * N_TERM
) (
    input  logic [LINK_W-1:0] links,
    input  logic [N_IN-1:0]   din,
    output logic [N_TERM-1:0] terms
);

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        logic prod;

        // Evaluate one product term over all inputs
        always_comb begin
            prod = 1'b1;
            for (int i = 0; i < N_IN; i++) begin
                if (links[and_true_idx(t, i, N_IN)] && !din[i]) prod = 1'b0;
                if (links[and_comp_idx(t, i, N_IN)] &&  din[i]) prod = 1'b0;
            end
        end

        assign terms[t] = prod;
    end

endmodule

// File: rtl/sop_or_plane.sv
// Module: OR plane with polarity control and output gating.
// Each output ORs its linked terms, XORs with its polarity bit, and is
// forced to 0 with a zero drive enable when chip_en is low.
module sop_or_plane #(
    parameter int N_TERM = 48,
    parameter int N_OUT  = 8,
    localparam int LINK_W = N_TERM * N_OUT
) (
    input  logic [LINK_W-1:0] links,
    input  logic [N_OUT-1:0]  pol,
    input  logic [N_TERM-1:0] terms,
    input  logic              chip_en,
    output logic [N_OUT-1:0]  dout,
    output logic [N_OUT-1:0]  dout_oe
);

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        logic sum;

        // Sum of the linked product terms for this output
        assign sum = |(terms & links[o*N_TERM +: N_TERM]);

        // Apply polarity and the enable gate
        assign dout[o]    = chip_en & (sum ^ pol[o]);
        assign dout_oe[o] = chip_en;
    end

endmodule

// File: rtl/sop_array_top.sv
// Module: configurable sum-of-products logic array (top).
// Holds the whole configuration in one serial register and evaluates the
// outputs combinationally from din. Layout from bit 0: polarity, OR
// links, AND links. Reset leaves every link present and no inversion.
module sop_array_top
    import sop_pkg::*;
#(
    parameter int N_IN   = 16,
    parameter int N_TERM = 48,
    parameter int N_OUT  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_en,
    input  logic             cfg_in,
    output logic             cfg_out,
    input  logic             chip_en,
    input  logic [N_IN-1:0]  din,
    output logic [N_OUT-1:0] dout,
    output logic [N_OUT-1:0] dout_oe
);

    localparam int AND_W = 2 * N_IN * N_TERM;
    localparam int OR_W  = N_TERM * N_OUT;
    localparam int CFG_W = cfg_width(N_IN, N_TERM, N_OUT);
    localparam logic [CFG_W-1:0] CFG_RST = {{(AND_W + OR_W){1'b1}}, {N_OUT{1'b0}}};

    logic [CFG_W-1:0]  chain_q;
    logic [N_TERM-1:0] terms;

    // Configuration storage
    sop_cfg_chain #(
        .WIDTH     (CFG_W),
        .RESET_VAL (CFG_RST)
    ) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (prog_en),
        .ser_in   (cfg_in),
        .ser_out  (cfg_out),
        .chain_q  (chain_q)
    );

    // Product terms
    sop_and_plane #(
        .N_IN   (N_IN),
        .N_TERM (N_TERM)
    ) and_i (
        .links (chain_q[N_OUT + OR_W +: AND_W]),
        .din   (din),
        .terms (terms)
    );

    // Sums, polarity and output gating
    sop_or_plane #(
        .N_TERM (N_TERM),
        .N_OUT  (N_OUT)
    ) or_i (
        .links   (chain_q[N_OUT +: OR_W]),
        .pol     (chain_q[N_OUT-1:0]),
        .terms   (terms),
        .chip_en (chip_en),
        .dout    (dout),
        .dout_oe (dout_oe)
    );

endmodule

// File: rtl/sop_array_chk.sv
// Module: assertion checker for sop_array_top, attached by bind.
// Assumes chain is the top's configuration register.
module sop_array_chk #(
    parameter int CFG_W = 8,
    parameter int N_OUT = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             prog_en,
    input logic             cfg_in,
    input logic             cfg_out,
    input logic             chip_en,
    input logic [N_OUT-1:0] dout,
    input logic [N_OUT-1:0] dout_oe,
    input logic [CFG_W-1:0] chain
);

    // R2
    shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |=> chain[0] == $past(cfg_in));

    // R2
    shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |=> chain[CFG_W-1:1] == $past(chain[CFG_W-2:0]));

    // R3
    hold_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_en |=> $stable(chain) && $stable(cfg_out));

    // R10
    disabled_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |-> (dout_oe == '0) && (dout == '0));

    // R10
    enabled_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chip_en |-> dout_oe == '1);

endmodule

bind sop_array_top sop_array_chk #(
    .CFG_W (CFG_W),
    .N_OUT (N_OUT)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .prog_en (prog_en),
    .cfg_in  (cfg_in),
    .cfg_out (cfg_out),
    .chip_en (chip_en),
    .dout    (dout),
    .dout_oe (dout_oe),
    .chain   (chain_q)
);

// File: tb/sop_array_top_tb_top.sv
`timescale 1ns/1ps
module sop_array_top_tb_top;

    localparam int NI  = 4;
    localparam int NT  = 6;
    localparam int NO  = 3;
    localparam int ORB = NO;            // first OR link bit
    localparam int ANB = NO + NO * NT;  // first AND link bit
    localparam int LEN = ANB + 2 * NI * NT;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prog_en = 1'b0;
    logic          cfg_in = 1'b0;
    logic          chip_en = 1'b0;
    logic [NI-1:0] din = '0;
    logic          cfg_out;
    logic [NO-1:0] dout;
    logic [NO-1:0] dout_oe;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sop_array_top #(.N_IN(NI), .N_TERM(NT), .N_OUT(NO)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .prog_en (prog_en),
        .cfg_in  (cfg_in),
        .cfg_out (cfg_out),
        .chip_en (chip_en),
        .din     (din),
        .dout    (dout),
        .dout_oe (dout_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference evaluation from the stated layout
    function automatic logic [NO-1:0] model(input logic [LEN-1:0] c, input logic [NI-1:0] x);
        logic [NO-1:0] r;
        for (int o = 0; o < NO; o++) begin
            logic s;
            s = 1'b0;
            for (int t = 0; t < NT; t++) begin
                logic p;
                p = 1'b1;
                for (int i = 0; i < NI; i++) begin
                    if (c[ANB + t*2*NI + 2*i + 1] && !x[i]) p = 1'b0;
                    if (c[ANB + t*2*NI + 2*i]     &&  x[i]) p = 1'b0;
                end
                if (c[ORB + o*NT + t]) s = s | p;
            end
            r[o] = s ^ c[o];
        end
        return r;
    endfunction

    function automatic logic [LEN-1:0] set_lit(input logic [LEN-1:0] c, input int t, input int i,
                                               input logic tr, input logic cm);
        logic [LEN-1:0] r;
        r = c;
        r[ANB + t*2*NI + 2*i + 1] = tr;
        r[ANB + t*2*NI + 2*i]     = cm;
        return r;
    endfunction

    // Shift a configuration in MSB-first; optionally check the readback of prev
    task automatic load(input logic [LEN-1:0] c, input logic [LEN-1:0] prev, input logic rb);
        @(negedge clk);
        prog_en = 1'b1;
        for (int k = LEN - 1; k >= 0; k--) begin
            cfg_in = c[k];
            #1;
            if (rb) chk("R2 readback", {31'd0, cfg_out}, {31'd0, prev[k]});
            @(negedge clk);
        end
        prog_en = 1'b0;
    endtask

    // All 16 input vectors against an expected-output function
    task automatic sweep(input logic [LEN-1:0] c, input logic ce, input string req);
        for (int x = 0; x < (1 << NI); x++) begin
            din = x[NI-1:0];
            chip_en = ce;
            #1;
            chk(req, {29'd0, dout}, ce ? {29'd0, model(c, x[NI-1:0])} : 32'd0);
            chk("R10 oe", {29'd0, dout_oe}, ce ? 32'h7 : 32'd0);
            #1;
        end
    endtask

    logic [LEN-1:0] rst_cfg;
    logic [LEN-1:0] cur;
    logic [LEN-1:0] nxt;
    logic [NO-1:0]  e;
    bit             done = 1'b0;

    initial begin
        rst_cfg = {{(LEN - NO){1'b1}}, {NO{1'b0}}};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset configuration gives all-zero outputs, full enable
        chip_en = 1'b1;
        for (int x = 0; x < (1 << NI); x++) begin
            din = x[NI-1:0];
            #1;
            chk("R1 dout", {29'd0, dout}, 32'd0);
            chk("R1 oe", {29'd0, dout_oe}, 32'h7);
        end

        // Directed config: term0 = x0 & ~x1, term1 = 1, term2 = x2, rest dead
        cur = rst_cfg;
        for (int t = 0; t < 3; t++)
            for (int i = 0; i < NI; i++) cur = set_lit(cur, t, i, 1'b0, 1'b0);
        cur = set_lit(cur, 0, 0, 1'b1, 1'b0);
        cur = set_lit(cur, 0, 1, 1'b0, 1'b1);
        cur = set_lit(cur, 2, 2, 1'b1, 1'b0);
        cur[ORB +: NO*NT] = '0;
        cur[ORB + 0*NT + 0] = 1'b1;
        cur[ORB + 0*NT + 2] = 1'b1;
        cur[ORB + 1*NT + 1] = 1'b1;
        for (int t = 3; t < NT; t++) cur[ORB + 2*NT + t] = 1'b1;
        cur[NO-1:0] = '0;
        // R1 R4: readback of the reset configuration during load
        load(cur, rst_cfg, 1'b1);
        chip_en = 1'b1;
        for (int x = 0; x < (1 << NI); x++) begin
            din = x[NI-1:0];
            #1;
            e[0] = (x[0] & ~x[1]) | x[2];
            e[1] = 1'b1;
            e[2] = 1'b0;
            chk("R5 R8 out0", {31'd0, dout[0]}, {31'd0, e[0]});
            chk("R6 out1", {31'd0, dout[1]}, {31'd0, e[1]});
            chk("R7 out2", {31'd0, dout[2]}, {31'd0, e[2]});
        end

        // Same config with every polarity bit set
        nxt = cur;
        nxt[NO-1:0] = '1;
        load(nxt, cur, 1'b1);
        cur = nxt;
        chip_en = 1'b1;
        for (int x = 0; x < (1 << NI); x++) begin
            din = x[NI-1:0];
            #1;
            e[0] = ~((x[0] & ~x[1]) | x[2]);
            chk("R9 out0", {31'd0, dout[0]}, {31'd0, e[0]});
            chk("R9 out1", {31'd0, dout[1]}, 32'd0);
            chk("R9 out2", {31'd0, dout[2]}, 32'd1);
        end

        // Random configurations, both chip enable levels
        for (int n = 0; n < 10; n++) begin
            nxt = '0;
            for (int k = 0; k < ANB; k++) nxt[k] = 1'($urandom_range(0, 1));
            for (int t = 0; t < NT; t++)
                for (int i = 0; i < NI; i++) begin
                    int r;
                    r = $urandom_range(0, 9);
                    nxt = set_lit(nxt, t, i, (r == 5 || r == 6 || r == 9), (r == 7 || r == 8 || r == 9));
                end
            load(nxt, cur, 1'b1);
            cur = nxt;
            sweep(cur, 1'b1, "R4 R5 R6 R7 R8 R9 random");
            sweep(cur, 1'b0, "R10 disabled");
        end

        // R3: toggle cfg_in with prog_en low; config must hold
        @(negedge clk);
        for (int k = 0; k < 20; k++) begin
            cfg_in = ~cfg_in;
            @(negedge clk);
        end
        sweep(cur, 1'b1, "R3 hold outputs");
        load(rst_cfg, cur, 1'b1);
        sweep(rst_cfg, 1'b1, "R1 reloaded");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule